// File: doc/BRIEF.md
# Gated Counter Readout

This block holds a free-running 64-bit count and lets two register frames read it: a privileged base frame and an unprivileged user frame. Each frame has a simple request port with a word address, a write flag and a wide-access flag, and returns read data with a valid strobe one cycle after the request. The count can never be written. Writes to the count addresses are ignored, and a read that is not permitted returns zero.

Permission forms a chain. The base frame sees the count when its read enable is high. The user frame sees it only when the base enable and the user enable are both high. A 32-bit reader gets a consistent pair of halves through a per-frame shadow: reading the low word captures the upper word, and a later high-word read returns that captured value. A 64-bit reader gets all bits from a single sample.

Top module: `cnt_readout_top`

## Requirements
- R1: After reset the count equals the parameter RST_VAL (zero by default), both valid strobes are low, and both shadows hold zero, so a high-word read made before any low-word read returns zero.
- R2: The count rises by exactly one on every clock cycle in which cnt_en is high, stays unchanged when cnt_en is low, and wraps from all-ones to zero.
- R3: A read request (req=1, wr=0) produces rvalid=1 on the next cycle only. A write request or no request produces rvalid=0 on the next cycle.
- R4: A permitted 32-bit read (wide=0) at byte offset 0x000 returns count bits [31:0] in rdata[31:0] with rdata[63:32] zero. The count is taken as it stands in the request cycle.
- R5: A permitted 32-bit read at offset 0x004 returns, in rdata[31:0], the count bits [63:32] captured by the most recent permitted 32-bit low-word read in the same frame. This holds even when the counter has carried into the upper word since that capture.
- R6: A permitted 64-bit read (wide=1) at offset 0x000 returns all 64 count bits sampled in the request cycle. A 64-bit read at any other offset returns zero.
- R7: Base-frame reads return zero unless base_pct_en is 1. A denied read does not update the shadow.
- R8: User-frame reads return zero unless both base_pct_en and user_pct_en are 1. A denied read does not update the shadow.
- R9: Writes to any offset in either frame change neither the count nor the shadows.
- R10: A read at any offset other than 0x000 or 0x004 returns zero.
- R11: The enable inputs are sampled in the cycle of the request. A change to an enable affects the next request made after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| base_pct_en | input | 1 | Base-frame count read permission |
| user_pct_en | input | 1 | User-frame count read permission (gated by base) |
| b_req | input | 1 | Base-frame access request |
| b_wr | input | 1 | Base-frame write flag (1 = write) |
| b_wide | input | 1 | Base-frame 64-bit access flag |
| b_addr | input | AW | Base-frame byte offset |
| b_rdata | output | 64 | Base-frame read data |
| b_rvalid | output | 1 | Base-frame read data valid |
| u_req | input | 1 | User-frame access request |
| u_wr | input | 1 | User-frame write flag (1 = write) |
| u_wide | input | 1 | User-frame 64-bit access flag |
| u_addr | input | AW | User-frame byte offset |
| u_rdata | output | 64 | User-frame read data |
| u_rvalid | output | 1 | User-frame read data valid |

## Verification
The sensitive coincidence is a permitted low-word read that samples the count in the same cycle as the counter's increment carrying from the low word into the high word. The bench resets the counter close to all-ones and steers a low-word read onto the last value before the carry, then issues a high-word read the cycle after. The high-word read must return the pre-carry upper word, while a 64-bit read around the same point must show the post-carry value. In a second coincidence both frames are read in the same cycle under different permissions, and each result is judged against its own permission chain and its own shadow.

// File: rtl/cntro_pkg.sv
package cntro_pkg;
    localparam int CNT_W  = 64;
    localparam int WORD_W = 32;
    localparam int NFRAME = 2;
    localparam int LO_OFS = 0;
    localparam int HI_OFS = 4;

    typedef struct packed {
        logic              rvalid;
        logic [CNT_W-1:0]  rdata;
        logic [WORD_W-1:0] shadow;
    } frame_st_t;
endpackage

// File: rtl/cntro_counter.sv
module cntro_counter
    import cntro_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (en) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q));
endmodule

// File: rtl/cntro_frame.sv
module cntro_frame
    import cntro_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             allow,
    input  logic             req,
    input  logic             wr,
    input  logic             wide,
    input  logic [AW-1:0]    addr,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] rdata,
    output logic             rvalid
);
    localparam int PAD_W = CNT_W - WORD_W;

    frame_st_t st_d, st_q;
    logic is_lo, is_hi, rd_ok;

    assign is_lo = (addr == AW'(LO_OFS));
    assign is_hi = (addr == AW'(HI_OFS));
    assign rd_ok = req & ~wr & allow;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = req & ~wr;
        st_d.rdata  = '0;
        if (rd_ok) begin
            if (wide) begin
                if (is_lo) st_d.rdata = count;
            end else if (is_lo) begin
                st_d.rdata  = {{PAD_W{1'b0}}, count[WORD_W-1:0]};
                st_d.shadow = count[CNT_W-1:WORD_W];
            end else if (is_hi) begin
                st_d.rdata  = {{PAD_W{1'b0}}, st_q.shadow};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.rdata;
    assign rvalid = st_q.rvalid;

    assert_rvalid_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr) |=> rvalid);
    assert_rvalid_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req || wr) |=> !rvalid);
    assert_narrow_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wide) |=> rdata[CNT_W-1:WORD_W] == '0);
    assert_deny_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !allow) |=> rdata == '0);
    assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req || wr || !allow) |=> $stable(st_q.shadow));
    assert_bad_ofs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !is_lo && !is_hi) |=> rdata == '0);
endmodule

// File: rtl/cnt_readout_top.sv
module cnt_readout_top
    import cntro_pkg::*;
#(
    parameter int               AW      = 12,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             base_pct_en,
    input  logic             user_pct_en,
    input  logic             b_req,
    input  logic             b_wr,
    input  logic             b_wide,
    input  logic [AW-1:0]    b_addr,
    output logic [CNT_W-1:0] b_rdata,
    output logic             b_rvalid,
    input  logic             u_req,
    input  logic             u_wr,
    input  logic             u_wide,
    input  logic [AW-1:0]    u_addr,
    output logic [CNT_W-1:0] u_rdata,
    output logic             u_rvalid
);
    logic [CNT_W-1:0]  count;
    logic [NFRAME-1:0] allow_v, req_v, wr_v, wide_v, rvalid_v;
    logic [AW-1:0]     addr_v  [NFRAME];
    logic [CNT_W-1:0]  rdata_v [NFRAME];

    cntro_counter #(.RST_VAL(RST_VAL)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .count (count)
    );

    // Frame 0 is the base frame; frame 1 inherits its permission.
    assign allow_v = {base_pct_en & user_pct_en, base_pct_en};
    assign req_v   = {u_req,  b_req};
    assign wr_v    = {u_wr,   b_wr};
    assign wide_v  = {u_wide, b_wide};
    assign addr_v[0] = b_addr;
    assign addr_v[1] = u_addr;

    for (genvar i = 0; i < NFRAME; i++) begin : g_frame
        cntro_frame #(.AW(AW)) u_frame (
            .clk    (clk),
            .rst_n  (rst_n),
            .allow  (allow_v[i]),
            .req    (req_v[i]),
            .wr     (wr_v[i]),
            .wide   (wide_v[i]),
            .addr   (addr_v[i]),
            .count  (count),
            .rdata  (rdata_v[i]),
            .rvalid (rvalid_v[i])
        );
    end

    assign b_rdata  = rdata_v[0];
    assign b_rvalid = rvalid_v[0];
    assign u_rdata  = rdata_v[1];
    assign u_rvalid = rvalid_v[1];

    assert_user_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (u_req && !base_pct_en) |=> u_rdata == '0);
    assert_base_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && !base_pct_en) |=> b_rdata == '0);
endmodule

// File: tb/cnt_readout_top_tb.sv
`timescale 1ns/1ps
module cnt_readout_top_tb;
    localparam int          AW  = 12;
    localparam logic [63:0] RST = 64'hFFFF_FFFF_FFFF_FF80;

    logic clk = 0, rst_n = 0, cnt_en = 0, base_pct_en = 0, user_pct_en = 0;
    logic b_req = 0, b_wr = 0, b_wide = 0, u_req = 0, u_wr = 0, u_wide = 0;
    logic [AW-1:0] b_addr = '0, u_addr = '0;
    logic [63:0] b_rdata, u_rdata;
    logic b_rvalid, u_rvalid;

    int total = 0, bad = 0;
    logic [63:0] mcnt;
    logic [31:0] shm [2];

    always #2.5 clk = ~clk;

    cnt_readout_top #(.AW(AW), .RST_VAL(RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en),
        .base_pct_en(base_pct_en), .user_pct_en(user_pct_en),
        .b_req(b_req), .b_wr(b_wr), .b_wide(b_wide), .b_addr(b_addr),
        .b_rdata(b_rdata), .b_rvalid(b_rvalid),
        .u_req(u_req), .u_wr(u_wr), .u_wide(u_wide), .u_addr(u_addr),
        .u_rdata(u_rdata), .u_rvalid(u_rvalid)
    );

    // Expected count from R1/R2: reset value plus enabled cycles, modulo 2^64.
    always @(posedge clk or negedge rst_n)
        if (!rst_n) mcnt <= RST;
        else if (cnt_en) mcnt <= mcnt + 64'd1;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        shm[0] = '0; shm[1] = '0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // Caller is at a negedge; drives a read, samples at the following negedge.
    task automatic rd(input int fr, input logic [AW-1:0] a, input logic wd,
                      output logic [63:0] d, output logic v, output logic [63:0] c);
        c = mcnt;
        if (fr == 0) begin b_req = 1; b_wr = 0; b_wide = wd; b_addr = a; end
        else         begin u_req = 1; u_wr = 0; u_wide = wd; u_addr = a; end
        @(negedge clk);
        b_req = 0; u_req = 0;
        d = (fr == 0) ? b_rdata : u_rdata;
        v = (fr == 0) ? b_rvalid : u_rvalid;
    endtask

    task automatic wr_op(input int fr, input logic [AW-1:0] a);
        if (fr == 0) begin b_req = 1; b_wr = 1; b_wide = 0; b_addr = a; end
        else         begin u_req = 1; u_wr = 1; u_wide = 0; u_addr = a; end
        @(negedge clk);
        b_req = 0; u_req = 0; b_wr = 0; u_wr = 0;
        check(((fr == 0) ? b_rvalid : u_rvalid) == 1'b0, "R3 write no valid",
              {63'd0, (fr == 0) ? b_rvalid : u_rvalid}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [63:0] d, c, prev, exp, d2;
        logic v, v2, allow;
        logic [AW-1:0] ofs [4];
        string tag;
        ofs[0] = 12'h000; ofs[1] = 12'h004; ofs[2] = 12'h008; ofs[3] = 12'hFFC;

        @(negedge clk);
        do_reset();

        // R1: reset state
        check(b_rvalid == 0 && u_rvalid == 0, "R1 valid low", {62'd0, b_rvalid, u_rvalid}, 64'd0);
        base_pct_en = 1; user_pct_en = 1;
        rd(0, 12'h004, 0, d, v, c);
        check(d == 64'd0, "R1 base shadow zero", d, 64'd0);
        rd(1, 12'h004, 0, d, v, c);
        check(d == 64'd0, "R1 user shadow zero", d, 64'd0);
        rd(0, 12'h000, 1, d, v, c);
        check(d == RST, "R1 reset count", d, RST);

        // R2: hold when disabled
        rd(0, 12'h000, 1, d, v, c);
        check(d == RST, "R2 hold", d, RST);

        // R2/R6: back-to-back 64-bit reads across wrap
        cnt_en = 1;
        prev = '0;
        for (int i = 0; i < 200; i++) begin
            rd(0, 12'h000, 1, d, v, c);
            check(d == c && v, "R6 wide sample", d, c);
            if (i > 0) check(d == prev + 64'd1, (c == 0) ? "R2 wrap" : "R2 step", d, prev + 64'd1);
            prev = d;
        end

        // Near-exhaustive sweep: permissions x frame x offset x width
        for (int pe = 0; pe < 2; pe++)
        for (int ue = 0; ue < 2; ue++)
        for (int fr = 0; fr < 2; fr++)
        for (int ai = 0; ai < 4; ai++)
        for (int wd = 0; wd < 2; wd++) begin
            base_pct_en = pe[0]; user_pct_en = ue[0];
            rd(fr, ofs[ai], wd[0], d, v, c);
            allow = (fr == 0) ? pe[0] : (pe[0] & ue[0]);
            exp = '0;
            if (!allow)          tag = (fr == 0) ? "R7" : "R8";
            else if (ai >= 2)    tag = "R10";
            else if (wd == 1)    begin tag = "R6"; if (ai == 0) exp = c; end
            else if (ai == 0)    begin tag = "R4"; exp = {32'd0, c[31:0]}; shm[fr] = c[63:32]; end
            else                 begin tag = "R5"; exp = {32'd0, shm[fr]}; end
            check(d == exp, tag, d, exp);
            check(v == 1'b1, "R3 read valid", {63'd0, v}, 64'd1);
        end
        @(negedge clk);
        check(b_rvalid == 0 && u_rvalid == 0, "R3 single-cycle valid", {62'd0, b_rvalid, u_rvalid}, 64'd0);

        // R9: writes leave count and shadow untouched
        base_pct_en = 1; user_pct_en = 1;
        rd(0, 12'h000, 0, d, v, c); shm[0] = c[63:32];
        rd(1, 12'h000, 0, d, v, c); shm[1] = c[63:32];
        for (int fr = 0; fr < 2; fr++) begin
            wr_op(fr, 12'h000);
            wr_op(fr, 12'h004);
        end
        rd(0, 12'h004, 0, d, v, c);
        check(d == {32'd0, shm[0]}, "R9 base shadow kept", d, {32'd0, shm[0]});
        rd(1, 12'h004, 0, d, v, c);
        check(d == {32'd0, shm[1]}, "R9 user shadow kept", d, {32'd0, shm[1]});
        rd(0, 12'h000, 1, d, v, c);
        check(d == c, "R9 count unaffected", d, c);

        // R11: enable sampled with the request
        user_pct_en = 0;
        rd(1, 12'h000, 1, d, v, c);
        check(d == 64'd0, "R11 off at request", d, 64'd0);
        user_pct_en = 1;
        rd(1, 12'h000, 1, d, v, c);
        check(d == c, "R11 on at request", d, c);

        // R5: low read on the last pre-carry value, high read after carry
        do_reset();
        cnt_en = 1;
        while (mcnt[31:0] != 32'hFFFF_FFFF) @(negedge clk);
        rd(0, 12'h000, 0, d, v, c);
        check(d == {32'd0, c[31:0]}, "R4 low at carry", d, {32'd0, c[31:0]});
        rd(0, 12'h004, 0, d, v, c);
        check(d == {32'd0, 32'hFFFF_FFFF}, "R5 shadow across carry", d, {32'd0, 32'hFFFF_FFFF});
        rd(0, 12'h000, 1, d, v, c);
        check(d == c && c[63:32] == 32'd0, "R6 post-carry wide", d, c);

        // Both frames in one cycle: base low read, user high read, user denied
        base_pct_en = 1; user_pct_en = 0;
        c = mcnt;
        b_req = 1; b_wr = 0; b_wide = 0; b_addr = 12'h000;
        u_req = 1; u_wr = 0; u_wide = 0; u_addr = 12'h004;
        @(negedge clk);
        b_req = 0; u_req = 0;
        d = b_rdata; d2 = u_rdata; v = b_rvalid; v2 = u_rvalid;
        check(d == {32'd0, c[31:0]} && v, "R4 dual base", d, {32'd0, c[31:0]});
        check(d2 == 64'd0 && v2, "R8 dual user denied", d2, 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule